// File: doc/BRIEF.md
# Multi-Queue Write Port Selector

This block is the write-side controller for a store that holds several logical queues in one shared storage array. A queue is chosen once, in a strobed selection cycle. The write port does not carry a queue address on every word. After that cycle, each enabled write is steered to the chosen queue. For each accepted word the block issues a registered write request: queue index, slot pointer and data. It then moves that queue's write pointer on by one.

Each queue keeps its own write pointer and occupancy count. The read side frees space by pulsing a per-queue release line. The full flag always describes the queue that is currently selected and is synchronous to the write clock. Selection is refused in two cases: before configuration is complete, and in a cycle where the flag-select strobe is also high. Either refusal sets a sticky error flag and keeps the current selection.

Top module: `mqw_write_port`

## Requirements
- R1: After a synchronous reset, the selected queue is 0, every queue is empty with its write pointer at 0, and `full`, `rule_err` and `req_we` are low.
- R2: At a clock edge where `sel_en` is high, `flag_sel` is low and `cfg_done` is high, the value on `sel_addr` becomes the selected queue shown on `cur_q` after that edge.
- R3: At a clock edge where `sel_en` and `flag_sel` are both high, `rule_err` is set and `cur_q` keeps its value.
- R4: At a clock edge where `sel_en` is high while `cfg_done` is low, `rule_err` is set and `cur_q` keeps its value.
- R5: Once set, `rule_err` stays high until reset, and reset clears it.
- R6: At an edge where `wr_en` is accepted, the next cycle shows `req_we` high, `req_q` equal to the queue selected before the edge, `req_ptr` equal to that queue's write pointer, and `req_data` equal to the sampled `wr_data`. That queue's pointer then increments by one modulo DEPTH.
- R7: A write changes only the selected queue's pointer and count. Other queues resume at their own pointers.
- R8: `full` is high exactly when the selected queue holds DEPTH words. It is valid from the cycle after the selection edge.
- R9: A write to a full queue is dropped. `req_we` stays low and the pointer does not move.
- R10: Writes are dropped while `cfg_done` is low, and the pointer does not move.
- R11: When a selection and a write fall on the same edge, the write goes to the queue that was selected before that edge.
- R12: A pulse on `q_release[i]` removes one word from queue i's count. A pulse on an empty queue is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Write clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_done | input | 1 | Configuration complete; enables selection and writes |
| sel_en | input | 1 | Queue-selection strobe |
| sel_addr | input | $clog2(NUM_Q) | Queue index sampled during a selection cycle |
| flag_sel | input | 1 | Flag-select strobe; must not coincide with `sel_en` |
| wr_en | input | 1 | Write enable |
| wr_data | input | DATA_W | Word to be written |
| q_release | input | NUM_Q | Per-queue one-word free pulse from the read side |
| cur_q | output | $clog2(NUM_Q) | Currently selected queue |
| full | output | 1 | Selected queue holds DEPTH words |
| rule_err | output | 1 | Sticky selection-rule violation |
| req_we | output | 1 | Registered write request to storage |
| req_q | output | $clog2(NUM_Q) | Queue of the write request |
| req_ptr | output | $clog2(DEPTH) | Slot within the queue |
| req_data | output | DATA_W | Data of the write request |

## Verification
A queue change and a write can fall on the same clock edge. The bench provokes this by raising `sel_en` with a new address and `wr_en` together. It judges the result by checking that the request carries the old queue index and that queue's next pointer, and that `cur_q` shows the new queue afterwards. A release and a refused write can also meet on a full queue: the bench confirms that the dropped word leaves the pointer alone and that space returns only through the release.

// File: rtl/mqw_pkg.sv
package mqw_pkg;

    // Outcome of a selection-strobe cycle
    typedef enum logic [1:0] {
        SEL_IDLE  = 2'd0,
        SEL_TAKE  = 2'd1,
        SEL_CLASH = 2'd2,
        SEL_EARLY = 2'd3
    } sel_act_e;

    // Decide what a cycle does to the queue selection
    function automatic sel_act_e classify_sel(
        input logic sel_en,
        input logic flag_sel,
        input logic cfg_done
    );
        if (!sel_en)        return SEL_IDLE;
        else if (flag_sel)  return SEL_CLASH;
        else if (!cfg_done) return SEL_EARLY;
        else                return SEL_TAKE;
    endfunction

    // Whether a write enable turns into an accepted write
    function automatic logic write_accept(
        input logic wr_en,
        input logic cfg_done,
        input logic q_full
    );
        return wr_en && cfg_done && !q_full;
    endfunction

endpackage

// File: rtl/mqw_select.sv
module mqw_select #(
    parameter int Q_W = 2
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           cfg_done,
    input  logic           sel_en,
    input  logic           flag_sel,
    input  logic [Q_W-1:0] sel_addr,
    output logic [Q_W-1:0] cur_q,
    output logic           rule_err
);
    import mqw_pkg::*;

    sel_act_e act;

    always_comb act = classify_sel(sel_en, flag_sel, cfg_done);

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q    <= '0;
            rule_err <= 1'b0;
        end else begin
            unique case (act)
                SEL_TAKE:  cur_q    <= sel_addr;
                SEL_CLASH: rule_err <= 1'b1;
                SEL_EARLY: rule_err <= 1'b1;
                default:   ;
            endcase
        end
    end
endmodule

// File: rtl/mqw_qstate.sv
module mqw_qstate #(
    parameter int NUM_Q = 4,
    parameter int DEPTH = 16,
    localparam int Q_W   = (NUM_Q > 1) ? $clog2(NUM_Q) : 1,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             acc,
    input  logic [Q_W-1:0]   acc_q,
    input  logic [NUM_Q-1:0] rel,
    output logic [PTR_W-1:0] ptr [NUM_Q],
    output logic [NUM_Q-1:0] full_vec
);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DEPTH);

    for (genvar g = 0; g < NUM_Q; g++) begin : g_q
        logic [CNT_W-1:0] cnt;
        logic             inc;
        logic             dec;

        always_comb begin
            inc = acc && (acc_q == Q_W'(g));
            dec = rel[g] && (cnt != '0);
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                ptr[g] <= '0;
                cnt    <= '0;
            end else begin
                if (inc) ptr[g] <= ptr[g] + 1'b1;
                if (inc && !dec)      cnt <= cnt + 1'b1;
                else if (dec && !inc) cnt <= cnt - 1'b1;
            end
        end

        assign full_vec[g] = (cnt == CNT_FULL);
    end
endmodule

// File: rtl/mqw_wreq.sv
module mqw_wreq #(
    parameter int Q_W    = 2,
    parameter int PTR_W  = 4,
    parameter int DATA_W = 36
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              acc,
    input  logic [Q_W-1:0]    acc_q,
    input  logic [PTR_W-1:0]  acc_ptr,
    input  logic [DATA_W-1:0] acc_data,
    output logic              req_we,
    output logic [Q_W-1:0]    req_q,
    output logic [PTR_W-1:0]  req_ptr,
    output logic [DATA_W-1:0] req_data
);
    always_ff @(posedge clk) begin
        if (rst) begin
            req_we   <= 1'b0;
            req_q    <= '0;
            req_ptr  <= '0;
            req_data <= '0;
        end else begin
            req_we <= acc;
            if (acc) begin
                req_q    <= acc_q;
                req_ptr  <= acc_ptr;
                req_data <= acc_data;
            end
        end
    end
endmodule

// File: rtl/mqw_write_port.sv
module mqw_write_port #(
    parameter int NUM_Q  = 4,
    parameter int DEPTH  = 16,
    parameter int DATA_W = 36,
    localparam int Q_W   = (NUM_Q > 1) ? $clog2(NUM_Q) : 1,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_done,
    input  logic              sel_en,
    input  logic [Q_W-1:0]    sel_addr,
    input  logic              flag_sel,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [NUM_Q-1:0]  q_release,
    output logic [Q_W-1:0]    cur_q,
    output logic              full,
    output logic              rule_err,
    output logic              req_we,
    output logic [Q_W-1:0]    req_q,
    output logic [PTR_W-1:0]  req_ptr,
    output logic [DATA_W-1:0] req_data
);
    import mqw_pkg::*;

    logic [PTR_W-1:0] ptr [NUM_Q];
    logic [NUM_Q-1:0] full_vec;
    logic             acc;

    mqw_select #(.Q_W(Q_W)) u_sel (
        .clk      (clk),
        .rst      (rst),
        .cfg_done (cfg_done),
        .sel_en   (sel_en),
        .flag_sel (flag_sel),
        .sel_addr (sel_addr),
        .cur_q    (cur_q),
        .rule_err (rule_err)
    );

    // Full of the currently selected queue; accept uses the pre-edge selection
    always_comb begin
        full = full_vec[cur_q];
        acc  = write_accept(wr_en, cfg_done, full);
    end

    mqw_qstate #(.NUM_Q(NUM_Q), .DEPTH(DEPTH)) u_qs (
        .clk      (clk),
        .rst      (rst),
        .acc      (acc),
        .acc_q    (cur_q),
        .rel      (q_release),
        .ptr      (ptr),
        .full_vec (full_vec)
    );

    mqw_wreq #(.Q_W(Q_W), .PTR_W(PTR_W), .DATA_W(DATA_W)) u_req (
        .clk      (clk),
        .rst      (rst),
        .acc      (acc),
        .acc_q    (cur_q),
        .acc_ptr  (ptr[cur_q]),
        .acc_data (wr_data),
        .req_we   (req_we),
        .req_q    (req_q),
        .req_ptr  (req_ptr),
        .req_data (req_data)
    );
endmodule

// File: rtl/mqw_write_port_chk.sv
module mqw_write_port_chk #(
    parameter int Q_W    = 2,
    parameter int PTR_W  = 4,
    parameter int DATA_W = 36
) (
    input logic              clk,
    input logic              rst,
    input logic              cfg_done,
    input logic              sel_en,
    input logic [Q_W-1:0]    sel_addr,
    input logic              flag_sel,
    input logic              wr_en,
    input logic [DATA_W-1:0] wr_data,
    input logic [Q_W-1:0]    cur_q,
    input logic              full,
    input logic              rule_err,
    input logic              req_we,
    input logic [Q_W-1:0]    req_q,
    input logic [DATA_W-1:0] req_data
);
    AST_SEL_LOADS: assert property (@(posedge clk) disable iff (rst)
        (sel_en && !flag_sel && cfg_done) |=> (cur_q == $past(sel_addr))); // R2
    AST_CLASH_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (sel_en && flag_sel) |=> (rule_err && $stable(cur_q))); // R3
    AST_EARLY_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (sel_en && !cfg_done) |=> (rule_err && $stable(cur_q))); // R4
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
        rule_err |=> rule_err); // R5
    AST_REQ_OLD_QUEUE: assert property (@(posedge clk) disable iff (rst)
        (wr_en && cfg_done && !full) |=> (req_we && req_q == $past(cur_q) && req_data == $past(wr_data))); // R6 R11
    AST_FULL_DROP: assert property (@(posedge clk) disable iff (rst)
        (wr_en && full) |=> !req_we); // R9
    AST_UNCFG_DROP: assert property (@(posedge clk) disable iff (rst)
        !cfg_done |=> !req_we); // R10
endmodule

bind mqw_write_port mqw_write_port_chk #(.Q_W(Q_W), .PTR_W(PTR_W), .DATA_W(DATA_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .cfg_done (cfg_done),
    .sel_en   (sel_en),
    .sel_addr (sel_addr),
    .flag_sel (flag_sel),
    .wr_en    (wr_en),
    .wr_data  (wr_data),
    .cur_q    (cur_q),
    .full     (full),
    .rule_err (rule_err),
    .req_we   (req_we),
    .req_q    (req_q),
    .req_data (req_data)
);

// File: tb/sim_mqw_write_port.sv
module sim_mqw_write_port;
    localparam int CLK_PERIOD = 10;
    localparam int NUM_Q  = 4;
    localparam int DEPTH  = 8;
    localparam int DATA_W = 36;
    localparam int Q_W    = 2;
    localparam int PTR_W  = 3;

    logic              clk = 1'b0;
    logic              rst;
    logic              cfg_done;
    logic              sel_en;
    logic [Q_W-1:0]    sel_addr;
    logic              flag_sel;
    logic              wr_en;
    logic [DATA_W-1:0] wr_data;
    logic [NUM_Q-1:0]  q_release;
    logic [Q_W-1:0]    cur_q;
    logic              full;
    logic              rule_err;
    logic              req_we;
    logic [Q_W-1:0]    req_q;
    logic [PTR_W-1:0]  req_ptr;
    logic [DATA_W-1:0] req_data;

    int checks = 0;
    int failures = 0;
    int exp_ptr [NUM_Q];

    always #(CLK_PERIOD/2) clk = ~clk;

    mqw_write_port #(.NUM_Q(NUM_Q), .DEPTH(DEPTH), .DATA_W(DATA_W)) u0 (
        .clk(clk), .rst(rst), .cfg_done(cfg_done), .sel_en(sel_en),
        .sel_addr(sel_addr), .flag_sel(flag_sel), .wr_en(wr_en),
        .wr_data(wr_data), .q_release(q_release), .cur_q(cur_q),
        .full(full), .rule_err(rule_err), .req_we(req_we), .req_q(req_q),
        .req_ptr(req_ptr), .req_data(req_data)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // One clock edge, then settle away from the edge; inputs return to idle
    task automatic tick();
        @(posedge clk);
        #1;
        sel_en    = 1'b0;
        flag_sel  = 1'b0;
        wr_en     = 1'b0;
        q_release = '0;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        tick();
        tick();
        rst = 1'b0;
        for (int i = 0; i < NUM_Q; i++) exp_ptr[i] = 0;
    endtask

    task automatic select(input int q);
        sel_en = 1'b1;
        sel_addr = Q_W'(q);
        tick();
    endtask

    // Accepted write expected into queue q
    task automatic write_ok(input int q, input logic [DATA_W-1:0] d, input string req);
        wr_en = 1'b1;
        wr_data = d;
        tick();
        check({req, " req_we"}, 64'(req_we), 64'd1);
        check({req, " req_q"}, 64'(req_q), 64'(q));
        check({req, " req_ptr"}, 64'(req_ptr), 64'(exp_ptr[q]));
        check({req, " req_data"}, 64'(req_data), 64'(d));
        exp_ptr[q] = (exp_ptr[q] + 1) % DEPTH;
    endtask

    task automatic t_reset_state();
        check("R1 cur_q", 64'(cur_q), 64'd0);
        check("R1 full", 64'(full), 64'd0);
        check("R1 rule_err", 64'(rule_err), 64'd0);
        check("R1 req_we", 64'(req_we), 64'd0);
    endtask

    task automatic t_unconfigured();
        select(2);
        check("R4 rule_err", 64'(rule_err), 64'd1);
        check("R4 cur_q held", 64'(cur_q), 64'd0);
        wr_en = 1'b1;
        wr_data = 36'h123;
        tick();
        check("R10 write dropped", 64'(req_we), 64'd0);
        tick();
        tick();
        check("R5 sticky", 64'(rule_err), 64'd1);
        do_reset();
        check("R5 cleared by reset", 64'(rule_err), 64'd0);
        cfg_done = 1'b1;
        write_ok(0, 36'hABC, "R10 pointer untouched");
    endtask

    task automatic t_select();
        select(2);
        check("R2 cur_q", 64'(cur_q), 64'd2);
        check("R8 full empty queue", 64'(full), 64'd0);
        check("R2 no error", 64'(rule_err), 64'd0);
    endtask

    task automatic t_pointers();
        select(0);
        write_ok(0, 36'h1, "R6");
        write_ok(0, 36'h2, "R6");
        tick();
        check("R6 idle no request", 64'(req_we), 64'd0);
        select(1);
        write_ok(1, 36'h3, "R7 other queue from 0");
        select(0);
        write_ok(0, 36'h4, "R7 resume queue 0");
    endtask

    task automatic t_same_edge();
        sel_en = 1'b1;
        sel_addr = 2'd1;
        write_ok(0, 36'h55, "R11 old queue");
        check("R11 new selection", 64'(cur_q), 64'd1);
    endtask

    task automatic t_fill();
        select(3);
        for (int i = 0; i < DEPTH; i++) begin
            check("R8 not full yet", 64'(full), 64'd0);
            write_ok(3, 36'(i + 16), "R8 fill");
        end
        check("R8 full", 64'(full), 64'd1);
        wr_en = 1'b1;
        wr_data = 36'hDEAD;
        tick();
        check("R9 dropped", 64'(req_we), 64'd0);
        q_release = 4'b1000;
        tick();
        check("R12 release clears full", 64'(full), 64'd0);
        write_ok(3, 36'h77, "R9 pointer held");
        check("R8 full again", 64'(full), 64'd1);
        select(2);
        check("R8 other queue", 64'(full), 64'd0);
        select(3);
        check("R8 valid after select edge", 64'(full), 64'd1);
    endtask

    task automatic t_release_empty();
        select(2);
        q_release = 4'b0100;
        tick();
        for (int i = 0; i < DEPTH - 1; i++) write_ok(2, 36'(i), "R12 refill");
        check("R12 empty release ignored", 64'(full), 64'd0);
        write_ok(2, 36'h99, "R12 last");
        check("R12 full at depth", 64'(full), 64'd1);
    endtask

    task automatic t_clash();
        select(0);
        sel_en = 1'b1;
        flag_sel = 1'b1;
        sel_addr = 2'd1;
        tick();
        check("R3 rule_err", 64'(rule_err), 64'd1);
        check("R3 cur_q held", 64'(cur_q), 64'd0);
        tick();
        check("R5 still set", 64'(rule_err), 64'd1);
    endtask

    initial begin
        rst = 1'b1;
        cfg_done = 1'b0;
        sel_en = 1'b0;
        sel_addr = '0;
        flag_sel = 1'b0;
        wr_en = 1'b0;
        wr_data = '0;
        q_release = '0;
        do_reset();
        t_reset_state();
        t_unconfigured();
        t_select();
        t_pointers();
        t_same_edge();
        t_fill();
        t_release_empty();
        t_clash();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule